// File: doc/BRIEF.md
# Condition Code Register Unit

This block holds the eight-bit status register of a small processor core and the flag generator that feeds it. Its arithmetic side accepts two 32-bit operands, a size select (byte, word or longword) and an operation select. In the same cycle it presents a zero-extended result and a write enable for that result. On the next clock edge it updates the half-carry, negative, zero, overflow and carry flags from the same computation. The half-carry flag is taken at a position that depends on the operand size. Add-with-carry and subtract-with-carry chain through the carry flag and keep the zero flag sticky, so a zero test across several words needs no extra instruction.

Software can load the whole register, or combine it with an immediate by AND, OR or XOR. Two bits of the register are free for software and have no effect on anything. One bit is an interrupt mask. Reset sets it, every exception entry forces it on, and it gates a vector of ordinary interrupt requests. The non-maskable request always passes through.

Top module: `ccr_unit`

## Requirements
- R1: Reset (rst_n low at a clock edge) leaves ccr_q at 8'h80: the mask bit (bit 7) set and all other bits clear, so every ordinary interrupt request is blocked.
- R2: A cycle with sw_valid high writes the register at the next edge: sw_op 0 loads sw_imm, 1 ANDs it in, 2 ORs it in, 3 XORs it in. If an arithmetic update is requested in the same cycle, the software write wins and the flags from the arithmetic side are dropped.
- R3: exc_entry high sets bit 7 at the next edge. When a software write arrives in the same cycle, the write is applied first and bit 7 is forced to 1 on top of it.
- R4: irq_take equals irq_req while bit 7 is 0 and is all zeros while bit 7 is 1. nmi_take follows nmi_req regardless of the register. int_mask shows bit 7. Bit 6 (the first user bit) has no effect on masking.
- R5: alu_size 0 selects byte, 1 selects word, and 2 or 3 select longword. Flag positions in the register are H bit 5, N bit 3, Z bit 2, V bit 1, C bit 0. After an operation, N is the top bit of the result at the active size, Z shows a zero result at that size, V shows signed overflow and C shows the carry out of, or borrow into, the top bit. Operand bits above the active size are ignored.
- R6: H shows the carry or borrow at bit 3 for byte, bit 11 for word and bit 27 for longword operations.
- R7: alu_op 1 (add-with-carry) computes a+b+C and alu_op 3 (subtract-with-carry) computes a-b-C. For these two, Z becomes 0 on a non-zero result and keeps its previous value on a zero result.
- R8: alu_op 4 (compare) sets the flags exactly as subtract (alu_op 2, a-b) does, but holds alu_wr low. alu_op 0 (add, a+b) and the other defined codes raise alu_wr while alu_valid is high.
- R9: alu_op 5 (negate) computes 0-a, and sets all flags as a subtraction with minuend 0 and subtrahend a.
- R10: alu_result is combinational in the cycle alu_valid is high, and is zero-extended above the active size. The flags appear in ccr_q after the next clock edge.
- R11: Arithmetic updates leave bits 7, 6 and 4 of the register unchanged.
- R12: alu_op codes 6 and 7 change nothing in the register and hold alu_wr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_valid | input | 1 | Arithmetic operation present this cycle |
| alu_op | input | 3 | Operation: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 negate |
| alu_size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| alu_a | input | 32 | First operand (minuend, or the value negated) |
| alu_b | input | 32 | Second operand (addend or subtrahend) |
| sw_valid | input | 1 | Software write to the register this cycle |
| sw_op | input | 2 | Software operation: 0 load, 1 AND, 2 OR, 3 XOR |
| sw_imm | input | 8 | Software immediate |
| exc_entry | input | 1 | Exception sequence starts this cycle |
| irq_req | input | 8 | Ordinary interrupt requests |
| nmi_req | input | 1 | Non-maskable interrupt request |
| alu_result | output | 32 | Zero-extended result |
| alu_wr | output | 1 | Result should be written back |
| ccr_q | output | 8 | Register contents |
| int_mask | output | 1 | Current mask bit |
| irq_take | output | 8 | Ordinary requests passed by the mask |
| nmi_take | output | 1 | Non-maskable request passed through |

## Verification
A wrong flag or mask bit in this block stays in ccr_q until something rewrites it. It shows on the ports one clock edge after the faulty update, and a bad mask bit also shows at once on irq_take. Errors in the carry chain or the size selection show at the same time on alu_result, in the same cycle as the operands. A sticky-zero or carry-in error only shows on the following chained operation. For that reason the chained sequences are checked after every step, not only at the end.

// File: rtl/ccr_pkg.sv
// Shared encodings for the condition code register unit.
// Assumes a fixed set of three operand sizes, each one twice the previous.
package ccr_pkg;
    localparam int DATA_W = 32;
    localparam int SZ_N   = 3;
    localparam int CCR_W  = 8;

    // register bit positions
    localparam int B_MASK  = 7;
    localparam int B_UMASK = 6;
    localparam int B_HALF  = 5;
    localparam int B_USER  = 4;
    localparam int B_NEG   = 3;
    localparam int B_ZERO  = 2;
    localparam int B_OVF   = 1;
    localparam int B_CARRY = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBC = 3'd3,
        OP_CMP  = 3'd4,
        OP_NEG  = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        SW_LOAD = 2'd0,
        SW_AND  = 2'd1,
        SW_OR   = 2'd2,
        SW_XOR  = 2'd3
    } sw_op_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;
endpackage

// File: rtl/ccr_operand_prep.sv
// Turns an operation code into adder inputs: every operation becomes
// x + y + cin, with y inverted for the subtracting ones.
// Assumes unknown codes must not touch any state (op_ok low).
module ccr_operand_prep
    import ccr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_flag,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         cin,
    output logic         is_sub,
    output logic         chain,
    output logic         op_ok,
    output logic         writes
);
    // Select adder inputs and mode bits for the current operation.
    always_comb begin
        x      = a;
        y      = b;
        cin    = 1'b0;
        is_sub = 1'b0;
        chain  = 1'b0;
        op_ok  = 1'b1;
        case (op)
            OP_ADD: ;
            OP_ADDC: begin
                cin   = carry_flag;
                chain = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                y      = ~b;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            OP_SUBC: begin
                y      = ~b;
                cin    = ~carry_flag;
                is_sub = 1'b1;
                chain  = 1'b1;
            end
            OP_NEG: begin
                x      = '0;
                y      = ~a;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            default: op_ok = 1'b0;
        endcase
    end

    // Compare updates flags only; everything else valid writes a result.
    assign writes = op_ok && (op != OP_CMP);
endmodule

// File: rtl/ccr_sum_flags.sv
// One full-width adder, with result and flag candidates taken at each
// operand size and one picked by the size select. Carries into a bit are
// recovered as x^y^sum at that bit, so upper operand bits never leak in.
// Assumes size codes at or above SZ_N mean the widest size.
module ccr_sum_flags
    import ccr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         is_sub,
    input  logic         chain,
    input  logic         z_prev,
    input  logic [1:0]   size,
    output logic [W-1:0] result,
    output flags_t       flags
);
    localparam int IDX_W = $clog2(SZ_N);

    logic [W:0]     xe, ye, sum;
    flags_t         cand  [SZ_N];
    logic [W-1:0]   res_k [SZ_N];
    logic [IDX_W-1:0] idx;

    assign xe  = {1'b0, x};
    assign ye  = {1'b0, y};
    assign sum = xe + ye + {{W{1'b0}}, cin};

    // Per-size carry, half-carry, sign, overflow and zero extraction.
    for (genvar k = 0; k < SZ_N; k++) begin : g_size
        localparam int WK = W >> (SZ_N - 1 - k);
        localparam int HP = WK - 4;
        logic co, ho, zr, ov, z_eff;
        assign co    = xe[WK] ^ ye[WK] ^ sum[WK];
        assign ho    = xe[HP] ^ ye[HP] ^ sum[HP];
        assign zr    = (sum[WK-1:0] == '0);
        assign ov    = (x[WK-1] == y[WK-1]) && (sum[WK-1] != x[WK-1]);
        assign z_eff = chain ? (z_prev & zr) : zr;
        assign cand[k]  = {ho ^ is_sub, sum[WK-1], z_eff, ov, co ^ is_sub};
        assign res_k[k] = W'(sum[WK-1:0]);
    end

    // Clamp out-of-range size codes to the widest size.
    always_comb begin
        if (int'(size) >= SZ_N) idx = IDX_W'(SZ_N - 1);
        else                    idx = size[IDX_W-1:0];
    end

    assign result = res_k[idx];
    assign flags  = cand[idx];
endmodule

// File: rtl/ccr_state.sv
// The register itself: software writes, flag updates and exception entry.
// Precedence: a software write beats a flag update, and exception entry is
// applied last so the mask bit always ends set.
module ccr_state
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_valid,
    input  logic [1:0]       sw_op,
    input  logic [CCR_W-1:0] sw_imm,
    input  logic             exc_entry,
    input  logic             alu_upd,
    input  flags_t           alu_flags,
    output logic [CCR_W-1:0] ccr_q
);
    logic [CCR_W-1:0] nxt;

    // Work out the next register value from all write sources.
    always_comb begin
        nxt = ccr_q;
        if (sw_valid) begin
            case (sw_op)
                SW_LOAD: nxt = sw_imm;
                SW_AND:  nxt = ccr_q & sw_imm;
                SW_OR:   nxt = ccr_q | sw_imm;
                default: nxt = ccr_q ^ sw_imm;
            endcase
        end else if (alu_upd) begin
            nxt[B_HALF]  = alu_flags.h;
            nxt[B_NEG]   = alu_flags.n;
            nxt[B_ZERO]  = alu_flags.z;
            nxt[B_OVF]   = alu_flags.v;
            nxt[B_CARRY] = alu_flags.c;
        end
        if (exc_entry) nxt[B_MASK] = 1'b1;
    end

    // Hold the register; reset leaves only the mask bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) ccr_q <= CCR_W'(1) << B_MASK;
        else        ccr_q <= nxt;
    end

    AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ccr_q == 8'h80); // R1
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_op == SW_LOAD && !exc_entry) |=> ccr_q == $past(sw_imm)); // R2
    AST_EXC_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> ccr_q[B_MASK]); // R3
    AST_ALU_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && !sw_valid && !exc_entry) |=>
        (ccr_q[B_MASK] == $past(ccr_q[B_MASK]) && ccr_q[B_UMASK] == $past(ccr_q[B_UMASK])
         && ccr_q[B_USER] == $past(ccr_q[B_USER]))); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_valid && !alu_upd && !exc_entry) |=> $stable(ccr_q)); // R12
endmodule

// File: rtl/ccr_irq_gate.sv
// Gates each ordinary request line with the mask bit; the non-maskable
// line bypasses the gate. Assumes requests are already synchronous.
module ccr_irq_gate #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             nmi_req,
    output logic [N_IRQ-1:0] irq_take,
    output logic             nmi_take
);
    // One gate per request line.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign irq_take[i] = irq_req[i] & ~mask;
    end

    assign nmi_take = nmi_req;

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> irq_take == '0); // R4
    AST_NMI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> nmi_take); // R4
endmodule

// File: rtl/ccr_unit.sv
// Top of the condition code register unit: operand preparation, the sized
// adder with flag extraction, the register and the interrupt gate.
// Assumes all inputs are synchronous to clk.
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alu_valid,
    input  logic [2:0]       alu_op,
    input  logic [1:0]       alu_size,
    input  logic [W-1:0]     alu_a,
    input  logic [W-1:0]     alu_b,
    input  logic             sw_valid,
    input  logic [1:0]       sw_op,
    input  logic [CCR_W-1:0] sw_imm,
    input  logic             exc_entry,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             nmi_req,
    output logic [W-1:0]     alu_result,
    output logic             alu_wr,
    output logic [CCR_W-1:0] ccr_q,
    output logic             int_mask,
    output logic [N_IRQ-1:0] irq_take,
    output logic             nmi_take
);
    logic [W-1:0] opx, opy;
    logic         cin, is_sub, chain, op_ok, writes;
    flags_t       flags;

    ccr_operand_prep #(.W(W)) u_prep (
        .op(alu_op), .a(alu_a), .b(alu_b), .carry_flag(ccr_q[B_CARRY]),
        .x(opx), .y(opy), .cin(cin), .is_sub(is_sub), .chain(chain),
        .op_ok(op_ok), .writes(writes)
    );

    ccr_sum_flags #(.W(W)) u_sum (
        .x(opx), .y(opy), .cin(cin), .is_sub(is_sub), .chain(chain),
        .z_prev(ccr_q[B_ZERO]), .size(alu_size),
        .result(alu_result), .flags(flags)
    );

    ccr_state u_state (
        .clk(clk), .rst_n(rst_n), .sw_valid(sw_valid), .sw_op(sw_op),
        .sw_imm(sw_imm), .exc_entry(exc_entry), .alu_upd(alu_valid && op_ok),
        .alu_flags(flags), .ccr_q(ccr_q)
    );

    ccr_irq_gate #(.N_IRQ(N_IRQ)) u_gate (
        .clk(clk), .rst_n(rst_n), .mask(ccr_q[B_MASK]), .irq_req(irq_req),
        .nmi_req(nmi_req), .irq_take(irq_take), .nmi_take(nmi_take)
    );

    assign alu_wr   = alu_valid && writes;
    assign int_mask = ccr_q[B_MASK];

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 3'd4) |-> !alu_wr); // R8
    AST_BAD_OP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op[2:1] == 2'b11) |-> !alu_wr); // R12
endmodule

// File: tb/ccr_unit_test.sv
module ccr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_valid = 1'b0;
    logic [2:0]  alu_op = '0;
    logic [1:0]  alu_size = '0;
    logic [31:0] alu_a = '0, alu_b = '0;
    logic        sw_valid = 1'b0;
    logic [1:0]  sw_op = '0;
    logic [7:0]  sw_imm = '0;
    logic        exc_entry = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        nmi_req = 1'b0;
    logic [31:0] alu_result;
    logic        alu_wr, int_mask, nmi_take;
    logic [7:0]  ccr_q, irq_take;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] exp_ccr;

    always #5 clk = ~clk;

    ccr_unit uut (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_size(alu_size), .alu_a(alu_a), .alu_b(alu_b), .sw_valid(sw_valid),
        .sw_op(sw_op), .sw_imm(sw_imm), .exc_entry(exc_entry), .irq_req(irq_req),
        .nmi_req(nmi_req), .alu_result(alu_result), .alu_wr(alu_wr), .ccr_q(ccr_q),
        .int_mask(int_mask), .irq_take(irq_take), .nmi_take(nmi_take)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference arithmetic, built from integer math at the requested width.
    function automatic void ref_alu(input int op, input int sz,
                                    input logic [31:0] a, input logic [31:0] b,
                                    input logic [7:0] cc,
                                    output logic [31:0] res, output logic [7:0] ncc);
        int w;
        logic [63:0] msk, hm, ua, ub, ci, full, hs;
        longint sa, sb, sr, mx, mn;
        logic c, h, v, z;
        w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        msk = (64'd1 << w) - 1;
        hm  = (64'd1 << (w - 4)) - 1;
        ua  = {32'd0, a} & msk;
        ub  = {32'd0, b} & msk;
        ci  = (op == 1 || op == 3) ? {63'd0, cc[0]} : 64'd0;
        if (op == 5) begin
            ub = {32'd0, a} & msk;
            ua = 64'd0;
        end
        sa = ua[w-1] ? longint'(ua) - longint'(64'd1 << w) : longint'(ua);
        sb = ub[w-1] ? longint'(ub) - longint'(64'd1 << w) : longint'(ub);
        mx = (longint'(1) << (w - 1)) - 1;
        mn = -(longint'(1) << (w - 1));
        if (op <= 1) begin
            full = ua + ub + ci;
            c    = full[w];
            hs   = (ua & hm) + (ub & hm) + ci;
            h    = hs[w-4];
            sr   = sa + sb + longint'(ci);
        end else begin
            full = ua - ub - ci;
            c    = (ua < ub + ci);
            h    = ((ua & hm) < ((ub & hm) + ci));
            sr   = sa - sb - longint'(ci);
        end
        res = full[31:0] & msk[31:0];
        v   = (sr > mx) || (sr < mn);
        z   = (res == 32'd0);
        if (op == 1 || op == 3) z = cc[2] & z;
        ncc    = cc;
        ncc[5] = h;
        ncc[3] = res[w-1];
        ncc[2] = z;
        ncc[1] = v;
        ncc[0] = c;
    endfunction

    task automatic do_alu(input int op, input int sz, input logic [31:0] a,
                          input logic [31:0] b, input string req);
        logic [31:0] er;
        logic [7:0]  ec;
        @(negedge clk);
        alu_valid = 1'b1; alu_op = op[2:0]; alu_size = sz[1:0]; alu_a = a; alu_b = b;
        #1;
        if (op <= 5) begin
            ref_alu(op, sz, a, b, exp_ccr, er, ec);
            check(req, "result", alu_result, er);
            check(req, "alu_wr", {31'd0, alu_wr}, {31'd0, op != 4});
        end else begin
            ec = exp_ccr;
            check(req, "alu_wr", {31'd0, alu_wr}, 32'd0);
        end
        @(negedge clk);
        alu_valid = 1'b0;
        #1;
        exp_ccr = ec;
        check(req, "ccr", {24'd0, ccr_q}, {24'd0, exp_ccr});
    endtask

    task automatic sw_write(input int op, input logic [7:0] imm, input logic [7:0] expv,
                            input string req);
        @(negedge clk);
        sw_valid = 1'b1; sw_op = op[1:0]; sw_imm = imm;
        @(negedge clk);
        sw_valid = 1'b0;
        #1;
        exp_ccr = expv;
        check(req, "ccr", {24'd0, ccr_q}, {24'd0, expv});
    endtask

    task automatic t_reset();
        irq_req = 8'hFF; nmi_req = 1'b1;
        #1;
        check("R1", "ccr after reset", {24'd0, ccr_q}, 32'h80);
        check("R1", "irq_take after reset", {24'd0, irq_take}, 32'h0);
        check("R4", "nmi passes", {31'd0, nmi_take}, 32'd1);
        irq_req = '0; nmi_req = 1'b0;
        exp_ccr = 8'h80;
    endtask

    task automatic t_sw_ops();
        sw_write(0, 8'h3C, 8'h3C, "R2");
        sw_write(1, 8'h0F, 8'h0C, "R2");
        sw_write(2, 8'hA0, 8'hAC, "R2");
        sw_write(3, 8'hFF, 8'h53, "R2");
        // software load and a carry-producing add in the same cycle
        @(negedge clk);
        sw_valid = 1'b1; sw_op = 2'd0; sw_imm = 8'h00;
        alu_valid = 1'b1; alu_op = 3'd0; alu_size = 2'd0; alu_a = 32'hFF; alu_b = 32'h01;
        @(negedge clk);
        sw_valid = 1'b0; alu_valid = 1'b0;
        #1;
        exp_ccr = 8'h00;
        check("R2", "sw beats alu", {24'd0, ccr_q}, 32'h00);
    endtask

    task automatic t_exception();
        @(negedge clk);
        exc_entry = 1'b1;
        @(negedge clk);
        exc_entry = 1'b0;
        #1;
        check("R3", "exc alone", {24'd0, ccr_q}, 32'h80);
        @(negedge clk);
        exc_entry = 1'b1; sw_valid = 1'b1; sw_op = 2'd3; sw_imm = 8'h81;
        @(negedge clk);
        exc_entry = 1'b0; sw_valid = 1'b0;
        #1;
        exp_ccr = 8'h81;
        check("R3", "exc after sw xor", {24'd0, ccr_q}, 32'h81);
    endtask

    task automatic t_irq();
        sw_write(0, 8'h40, 8'h40, "R4");
        irq_req = 8'h5A; nmi_req = 1'b1;
        #1;
        check("R4", "unmasked take (UI set)", {24'd0, irq_take}, 32'h5A);
        check("R4", "int_mask low", {31'd0, int_mask}, 32'd0);
        sw_write(0, 8'h80, 8'h80, "R4");
        check("R4", "masked take", {24'd0, irq_take}, 32'h00);
        check("R4", "nmi while masked", {31'd0, nmi_take}, 32'd1);
        irq_req = '0; nmi_req = 1'b0;
    endtask

    task automatic t_add_sizes();
        sw_write(0, 8'h00, 8'h00, "R5");
        do_alu(0, 0, 32'h7F, 32'h01, "R5");
        do_alu(0, 0, 32'hFF, 32'h01, "R5");
        do_alu(0, 0, 32'hABCD_12F0, 32'h1111_0010, "R5");
        do_alu(0, 1, 32'h0000_7FFF, 32'h0000_0001, "R5");
        do_alu(0, 2, 32'hFFFF_FFFF, 32'h0000_0001, "R5");
        do_alu(0, 3, 32'h8000_0000, 32'h8000_0000, "R5");
        do_alu(2, 1, 32'h0000_0003, 32'h0000_0005, "R5");
        do_alu(2, 2, 32'h8000_0000, 32'h0000_0001, "R10");
    endtask

    task automatic t_half_carry();
        do_alu(0, 1, 32'h0800, 32'h0800, "R6");
        do_alu(0, 0, 32'h0800, 32'h0800, "R6");
        do_alu(0, 2, 32'h0800_0000, 32'h0800_0000, "R6");
        do_alu(0, 1, 32'h0008, 32'h0008, "R6");
        do_alu(2, 0, 32'h10, 32'h01, "R6");
        do_alu(2, 1, 32'h1000, 32'h0001, "R6");
    endtask

    task automatic t_chain();
        sw_write(0, 8'h05, 8'h05, "R7");
        do_alu(1, 0, 32'h00, 32'hFF, "R7");
        check("R7", "zero kept set", {31'd0, ccr_q[2]}, 32'd1);
        do_alu(1, 0, 32'h01, 32'h00, "R7");
        check("R7", "nonzero clears Z", {31'd0, ccr_q[2]}, 32'd0);
        do_alu(1, 0, 32'h00, 32'h00, "R7");
        check("R7", "zero keeps Z clear", {31'd0, ccr_q[2]}, 32'd0);
        sw_write(0, 8'h04, 8'h04, "R7");
        do_alu(2, 2, 32'h0000_0000, 32'h0000_0001, "R7");
        do_alu(3, 2, 32'h0000_0001, 32'h0000_0000, "R7");
        do_alu(3, 1, 32'h0000_0000, 32'h0000_0000, "R7");
    endtask

    task automatic t_compare();
        do_alu(4, 0, 32'h05, 32'h05, "R8");
        do_alu(4, 0, 32'h03, 32'h05, "R8");
        do_alu(4, 2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8");
    endtask

    task automatic t_negate();
        do_alu(5, 0, 32'h80, 32'h0, "R9");
        do_alu(5, 0, 32'h00, 32'h0, "R9");
        do_alu(5, 1, 32'h0001, 32'h1234, "R9");
        do_alu(5, 2, 32'h0000_0010, 32'h0, "R9");
    endtask

    task automatic t_user_bits();
        sw_write(0, 8'h50, 8'h50, "R11");
        do_alu(0, 0, 32'hFF, 32'hFF, "R11");
        check("R11", "ctrl bits kept", {29'd0, ccr_q[7], ccr_q[6], ccr_q[4]}, 32'h3);
        do_alu(6, 0, 32'h01, 32'h01, "R12");
        do_alu(7, 2, 32'hFFFF_FFFF, 32'h1, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw_ops();
        t_exception();
        t_irq();
        t_add_sizes();
        t_half_carry();
        t_chain();
        t_compare();
        t_negate();
        t_user_bits();
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule